// File: doc/BRIEF.md
# Gated Program/Read FIFO Pair with Watermark Interrupts

This block sits between a register bus and a flash operation engine and carries data words in both directions through two first-in first-out buffers of 16 words of 32 bits each. The program buffer is loaded by software and unloaded by the engine. The read buffer is loaded by the engine and unloaded by software. Each buffer reports full and empty status. Four interrupt sources are raised as single-cycle pulses: program buffer became empty, program buffer drained down to its watermark, read buffer became full, and read buffer filled up to its watermark.

A small gate state machine decides whether software may load the program buffer. It has three states. GATE_CLEAR is entered from any state on any clock edge where `fifo_clr_i` is high. GATE_IDLE is the reset state and is entered from GATE_CLEAR on the first edge with `fifo_clr_i` low, or from GATE_PROG on an edge with `prog_op_i` low. GATE_PROG is entered from GATE_IDLE on an edge with `prog_op_i` high and is held while `prog_op_i` stays high. Software writes are accepted only in GATE_PROG. While `fifo_clr_i` is high, both buffers are held empty.

Each watermark input is 5 bits wide. The intended reset value is 15. With that value the read watermark condition is false at reset, and the program watermark pulse is suppressed because its edge detector starts out in the true state.

Top module: `gated_fifo_pair`

## Requirements
- R1: Each buffer holds up to 16 words of 32 bits and returns them in the order they were written. `eng_prog_rdata_o` and `sw_rd_rdata_o` show the oldest word.
- R2: A software program write (`sw_prog_we_i`) is stored only when the gate is in GATE_PROG, following the transitions given above. Otherwise it is ignored.
- R3: A write to a buffer that already holds 16 words is dropped, and the stored contents stay unchanged.
- R4: A pop from an empty buffer changes nothing. The data output of an empty buffer is 0.
- R5: While `fifo_clr_i` is high, both buffers become empty at the next edge and stay empty. Any write in that cycle is dropped.
- R6: The status outputs show full (16 words) and empty (0 words) for each buffer. After reset both empty flags are 1 and both full flags are 0.
- R7: `irq_prog_empty_o` is high for one cycle in the first cycle in which the program buffer holds 0 words after holding words.
- R8: `irq_prog_lvl_o` is high for one cycle when the condition program occupancy <= `wm_prog_i` changes from false to true.
- R9: `irq_rd_full_o` is high for one cycle when the read buffer first holds 16 words.
- R10: `irq_rd_lvl_o` is high for one cycle when the condition read occupancy >= `wm_rd_i` changes from false to true.
- R11: With both watermarks at 15, no interrupt is raised after reset until data moves.
- R12: A push and a pop on the same buffer in the same cycle both take effect, unless the buffer is empty (only the push happens) or full (only the pop happens).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_clr_i | input | 1 | Level-held clear of both buffers |
| prog_op_i | input | 1 | A program operation is active |
| wm_prog_i | input | 5 | Program drain watermark |
| wm_rd_i | input | 5 | Read fill watermark |
| sw_prog_we_i | input | 1 | Software write to the program buffer |
| sw_prog_wdata_i | input | 32 | Software write data |
| eng_prog_re_i | input | 1 | Engine pops the program buffer |
| eng_prog_rdata_o | output | 32 | Oldest program word, 0 when empty |
| eng_rd_we_i | input | 1 | Engine pushes into the read buffer |
| eng_rd_wdata_i | input | 32 | Engine write data |
| sw_rd_re_i | input | 1 | Software pops the read buffer |
| sw_rd_rdata_o | output | 32 | Oldest read word, 0 when empty |
| stat_prog_full_o | output | 1 | Program buffer full |
| stat_prog_empty_o | output | 1 | Program buffer empty |
| stat_rd_full_o | output | 1 | Read buffer full |
| stat_rd_empty_o | output | 1 | Read buffer empty |
| irq_prog_empty_o | output | 1 | Program-empty pulse |
| irq_prog_lvl_o | output | 1 | Program-watermark pulse |
| irq_rd_full_o | output | 1 | Read-full pulse |
| irq_rd_lvl_o | output | 1 | Read-watermark pulse |

## Verification
Two events can fall in the same cycle on one buffer: a push and a pop. The case with a full buffer, where the push is dropped and the pop proceeds, and the case with an empty buffer, where only the push lands, are the edges most easily got wrong. The bench drives pushes and pops directly at both ends of each buffer. It then runs long random phases with high push and pop rates, which keep the buffers near their limits. Every cycle, the outputs are compared with a queue model that applies the pop to the old contents and accepts a push only if the old occupancy was below 16. A clear can also coincide with writes, and the model drops those writes.

// File: rtl/gfp_pkg.sv
package gfp_pkg;

    typedef enum logic [1:0] {
        GATE_CLEAR = 2'd0,
        GATE_IDLE  = 2'd1,
        GATE_PROG  = 2'd2
    } gate_state_e;

endpackage

// File: rtl/gfp_fifo.sv
module gfp_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pop_i,
    output logic [DW-1:0] rdata_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);
    assign push_ok = push_i && !full_o && !clr_i;
    assign pop_ok  = pop_i && !empty_o && !clr_i;
    assign rdata_o = empty_o ? '0 : mem_q[rptr_q];
    assign count_o = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else if (clr_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_ok) mem_q[wptr_q] <= wdata_i;
    end

endmodule

// File: rtl/gfp_gate.sv
module gfp_gate
    import gfp_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic prog_op_i,
    output logic open_o
);

    gate_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= GATE_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = GATE_CLEAR;
        end else begin
            unique case (state_q)
                GATE_CLEAR: state_d = GATE_IDLE;
                GATE_IDLE:  state_d = prog_op_i ? GATE_PROG : GATE_IDLE;
                GATE_PROG:  state_d = prog_op_i ? GATE_PROG : GATE_IDLE;
                default:    state_d = GATE_IDLE;
            endcase
        end
    end

    always_comb begin
        open_o = (state_q == GATE_PROG);
    end

endmodule

// File: rtl/gfp_edge_irq.sv
module gfp_edge_irq #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cond_i,
    output logic irq_o
);

    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= RST_VAL;
        else         prev_q <= cond_i;
    end

    assign irq_o = cond_i && !prev_q;

endmodule

// File: rtl/gated_fifo_pair.sv
module gated_fifo_pair #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fifo_clr_i,
    input  logic          prog_op_i,
    input  logic [LW-1:0] wm_prog_i,
    input  logic [LW-1:0] wm_rd_i,
    input  logic          sw_prog_we_i,
    input  logic [DW-1:0] sw_prog_wdata_i,
    input  logic          eng_prog_re_i,
    output logic [DW-1:0] eng_prog_rdata_o,
    input  logic          eng_rd_we_i,
    input  logic [DW-1:0] eng_rd_wdata_i,
    input  logic          sw_rd_re_i,
    output logic [DW-1:0] sw_rd_rdata_o,
    output logic          stat_prog_full_o,
    output logic          stat_prog_empty_o,
    output logic          stat_rd_full_o,
    output logic          stat_rd_empty_o,
    output logic          irq_prog_empty_o,
    output logic          irq_prog_lvl_o,
    output logic          irq_rd_full_o,
    output logic          irq_rd_lvl_o
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int NIRQ = 4;

    logic          gate_open;
    logic [CW-1:0] prog_cnt, rd_cnt;
    logic [NIRQ-1:0] irq_cond, irq_vec;

    gfp_gate u_gate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (fifo_clr_i),
        .prog_op_i (prog_op_i),
        .open_o    (gate_open)
    );

    gfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_prog_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (fifo_clr_i),
        .push_i  (sw_prog_we_i && gate_open),
        .wdata_i (sw_prog_wdata_i),
        .pop_i   (eng_prog_re_i),
        .rdata_o (eng_prog_rdata_o),
        .count_o (prog_cnt),
        .full_o  (stat_prog_full_o),
        .empty_o (stat_prog_empty_o)
    );

    gfp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rd_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (fifo_clr_i),
        .push_i  (eng_rd_we_i),
        .wdata_i (eng_rd_wdata_i),
        .pop_i   (sw_rd_re_i),
        .rdata_o (sw_rd_rdata_o),
        .count_o (rd_cnt),
        .full_o  (stat_rd_full_o),
        .empty_o (stat_rd_empty_o)
    );

    // index 0: prog empty, 1: prog watermark, 2: read full, 3: read watermark
    assign irq_cond[0] = stat_prog_empty_o;
    assign irq_cond[1] = (int'(prog_cnt) <= int'(wm_prog_i));
    assign irq_cond[2] = stat_rd_full_o;
    assign irq_cond[3] = (int'(rd_cnt) >= int'(wm_rd_i));

    // program-side conditions are true at reset; edge detectors start set
    localparam logic [NIRQ-1:0] IRQ_RST = 4'b0011;

    for (genvar gi = 0; gi < NIRQ; gi++) begin : g_irq
        gfp_edge_irq #(.RST_VAL(IRQ_RST[gi])) u_edge (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .cond_i (irq_cond[gi]),
            .irq_o  (irq_vec[gi])
        );
    end

    assign irq_prog_empty_o = irq_vec[0];
    assign irq_prog_lvl_o   = irq_vec[1];
    assign irq_rd_full_o    = irq_vec[2];
    assign irq_rd_lvl_o     = irq_vec[3];

endmodule

// File: rtl/gated_fifo_pair_chk.sv
module gated_fifo_pair_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        fifo_clr_i,
    input logic        prog_op_i,
    input logic        stat_prog_full_o,
    input logic        stat_prog_empty_o,
    input logic        stat_rd_full_o,
    input logic        stat_rd_empty_o,
    input logic [31:0] sw_rd_rdata_o,
    input logic [31:0] eng_prog_rdata_o,
    input logic        irq_prog_empty_o,
    input logic        irq_rd_full_o
);

    AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_clr_i |=> (stat_prog_empty_o && stat_rd_empty_o)); // R5

    AST_GATE_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!prog_op_i ##1 stat_prog_empty_o) |=> stat_prog_empty_o); // R2

    AST_RD_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_rd_empty_o |-> (sw_rd_rdata_o == 32'd0)); // R4

    AST_PROG_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_prog_empty_o |-> (eng_prog_rdata_o == 32'd0)); // R4

    AST_NO_FULL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(stat_rd_full_o && stat_rd_empty_o) && !(stat_prog_full_o && stat_prog_empty_o)); // R6

    AST_PE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_prog_empty_o |=> !irq_prog_empty_o); // R7

    AST_RF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_rd_full_o |=> !irq_rd_full_o); // R9

endmodule

bind gated_fifo_pair gated_fifo_pair_chk u_chk (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .fifo_clr_i        (fifo_clr_i),
    .prog_op_i         (prog_op_i),
    .stat_prog_full_o  (stat_prog_full_o),
    .stat_prog_empty_o (stat_prog_empty_o),
    .stat_rd_full_o    (stat_rd_full_o),
    .stat_rd_empty_o   (stat_rd_empty_o),
    .sw_rd_rdata_o     (sw_rd_rdata_o),
    .eng_prog_rdata_o  (eng_prog_rdata_o),
    .irq_prog_empty_o  (irq_prog_empty_o),
    .irq_rd_full_o     (irq_rd_full_o)
);

// File: tb/gated_fifo_pair_tb_top.sv
`timescale 1ns/1ps
module gated_fifo_pair_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        fifo_clr_i = 1'b0;
    logic        prog_op_i = 1'b0;
    logic [4:0]  wm_prog_i = 5'd15;
    logic [4:0]  wm_rd_i = 5'd15;
    logic        sw_prog_we_i = 1'b0;
    logic [31:0] sw_prog_wdata_i = '0;
    logic        eng_prog_re_i = 1'b0;
    logic [31:0] eng_prog_rdata_o;
    logic        eng_rd_we_i = 1'b0;
    logic [31:0] eng_rd_wdata_i = '0;
    logic        sw_rd_re_i = 1'b0;
    logic [31:0] sw_rd_rdata_o;
    logic        stat_prog_full_o, stat_prog_empty_o, stat_rd_full_o, stat_rd_empty_o;
    logic        irq_prog_empty_o, irq_prog_lvl_o, irq_rd_full_o, irq_rd_lvl_o;

    always #2.5 clk_i = ~clk_i;

    gated_fifo_pair dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] pq[$];
    logic [31:0] rq[$];
    int  mgate = 1;            // 0 clear, 1 idle, 2 prog
    bit  pv_pe = 1, pv_pl = 1, pv_rf = 0, pv_rl = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit c_pl(int n); return n <= int'(wm_prog_i); endfunction
    function automatic bit c_rl(int n); return n >= int'(wm_rd_i); endfunction

    task automatic check_all();
        bit pe = (pq.size() == 0);
        bit rf = (rq.size() == 16);
        chk("R1 prog head", eng_prog_rdata_o, pe ? 32'd0 : pq[0]);
        chk("R1 R4 read head", sw_rd_rdata_o, (rq.size() == 0) ? 32'd0 : rq[0]);
        chk("R6 prog empty", 32'(stat_prog_empty_o), 32'(pe));
        chk("R6 prog full", 32'(stat_prog_full_o), 32'(pq.size() == 16));
        chk("R6 rd empty", 32'(stat_rd_empty_o), 32'(rq.size() == 0));
        chk("R6 rd full", 32'(stat_rd_full_o), 32'(rf));
        chk("R7 irq prog empty", 32'(irq_prog_empty_o), 32'(pe && !pv_pe));
        chk("R8 irq prog lvl", 32'(irq_prog_lvl_o), 32'(c_pl(pq.size()) && !pv_pl));
        chk("R9 irq rd full", 32'(irq_rd_full_o), 32'(rf && !pv_rf));
        chk("R10 irq rd lvl", 32'(irq_rd_lvl_o), 32'(c_rl(rq.size()) && !pv_rl));
    endtask

    // apply model for the current inputs, advance one clock, check
    task automatic step();
        int ps = pq.size();
        int rs = rq.size();
        pv_pe = (ps == 0);
        pv_pl = c_pl(ps);
        pv_rf = (rs == 16);
        pv_rl = c_rl(rs);
        if (fifo_clr_i) begin
            pq.delete();
            rq.delete();
        end else begin
            // R12: pop uses old contents, push checks old occupancy
            if (eng_prog_re_i && ps > 0) void'(pq.pop_front());
            if (sw_prog_we_i && mgate == 2 && ps < 16) pq.push_back(sw_prog_wdata_i);
            if (sw_rd_re_i && rs > 0) void'(rq.pop_front());
            if (eng_rd_we_i && rs < 16) rq.push_back(eng_rd_wdata_i);
        end
        if (fifo_clr_i) mgate = 0;
        else if (mgate == 0) mgate = 1;
        else mgate = prog_op_i ? 2 : 1;
        @(posedge clk_i);
        @(negedge clk_i);
        check_all();
    endtask

    task automatic idle_in();
        sw_prog_we_i = 0; eng_prog_re_i = 0; eng_rd_we_i = 0; sw_rd_re_i = 0;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0007));
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        check_all();                        // R6 R11 reset state
        chk("R11 no irq after reset", 32'({irq_prog_empty_o, irq_prog_lvl_o,
            irq_rd_full_o, irq_rd_lvl_o}), 32'd0);
        repeat (2) step();

        // R2: writes with no program operation are ignored
        sw_prog_we_i = 1;
        for (int i = 0; i < 4; i++) begin sw_prog_wdata_i = 32'hA000 + i; step(); end
        chk("R2 closed gate ignores writes", 32'(stat_prog_empty_o), 32'd1);

        // open gate and overfill: R3
        prog_op_i = 1;
        for (int i = 0; i < 20; i++) begin sw_prog_wdata_i = 32'hB000 + i; step(); end
        chk("R3 prog full after overfill", 32'(stat_prog_full_o), 32'd1);
        chk("R3 head kept", eng_prog_rdata_o, 32'hB001);

        // R12 full with push+pop: only pop
        eng_prog_re_i = 1; sw_prog_wdata_i = 32'hC0DE;
        step();
        chk("R12 full push+pop keeps 15", 32'(stat_prog_full_o), 32'd0);
        sw_prog_we_i = 0;
        wm_prog_i = 5'd4;
        repeat (18) step();                 // drain, R4 pop on empty, R7 R8
        chk("R4 empty prog reads zero", eng_prog_rdata_o, 32'd0);
        idle_in(); prog_op_i = 0;

        // read buffer fill with watermark, R9 R10, then empty reads R4
        wm_rd_i = 5'd6;
        eng_rd_we_i = 1;
        for (int i = 0; i < 18; i++) begin eng_rd_wdata_i = 32'hD000 + i; step(); end
        chk("R3 read full after overfill", 32'(stat_rd_full_o), 32'd1);
        eng_rd_we_i = 0; sw_rd_re_i = 1;
        repeat (18) step();
        chk("R4 empty read data zero", sw_rd_rdata_o, 32'd0);
        // R12 empty with push+pop: push lands
        eng_rd_we_i = 1; eng_rd_wdata_i = 32'h1234_5678;
        step();
        chk("R12 empty push+pop stores", sw_rd_rdata_o, 32'h1234_5678);
        idle_in();

        // R5: clear held while writes arrive
        eng_rd_we_i = 1; prog_op_i = 1; sw_prog_we_i = 1;
        repeat (4) step();
        fifo_clr_i = 1;
        repeat (3) step();
        chk("R5 clear empties read", 32'(stat_rd_empty_o), 32'd1);
        chk("R5 clear empties prog", 32'(stat_prog_empty_o), 32'd1);
        fifo_clr_i = 0;
        idle_in();
        repeat (3) step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0) begin
                wm_prog_i = 5'($urandom_range(0, 16));
                wm_rd_i   = 5'($urandom_range(0, 16));
            end
            prog_op_i       = ($urandom_range(0, 9) != 0);
            fifo_clr_i      = ($urandom_range(0, 99) == 0);
            sw_prog_we_i    = ($urandom_range(0, 1) == 1);
            sw_prog_wdata_i = $urandom;
            eng_prog_re_i   = ($urandom_range(0, 2) == 0);
            eng_rd_we_i     = ($urandom_range(0, 1) == 1);
            eng_rd_wdata_i  = $urandom;
            sw_rd_re_i      = ($urandom_range(0, 2) == 0);
            step();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule